// File: doc/BRIEF.md
# Up/Down Free-Running Timer with Buffered Period

A free-running counter of 16 bits that advances once per count tick and folds back at a programmable compare-clear value. It has two counting shapes. In sawtooth mode it counts up and wraps to zero after reaching the compare-clear value. In triangle mode it climbs to that value, then descends to zero, then climbs again. Each fold raises a one-cycle event pulse and a sticky status flag. Each flag has its own interrupt enable.

The count tick comes from one of two places: a one-cycle enable from an external prescaler, or rising edges of an asynchronous clock pin, which pass through a synchroniser. The compare-clear value can be staged in a shadow register and copied into the active register only at a period boundary, so a new period takes effect without a partial cycle. Software reaches the timer data, compare-clear and control/status words over a small register bus with byte enables. That bus has no back-pressure. A write is taken in the cycle its strobe is high, and read data is combinational from the selected word.

Top module: `frt_timer`

## Requirements
- R1: After reset the count reads 0x0000, the compare-clear word reads 0xFFFF, the control/status word reads 0x0000, and the direction output is 0.
- R2: In sawtooth mode (control bit 2 = 0), each tick adds 1 to the count. A tick that finds the count equal to the compare-clear value C sets it to 0 instead. From 0, after n ticks the count is n mod (C+1). That tick also sets the compare flag (bit 8) and drives cc_pulse high for the following cycle.
- R3: In triangle mode (bit 2 = 1), the count runs from 0 up to C and back down to 0. After n ticks from 0 the count is p if p ≤ C and 2C−p otherwise, where p = n mod 2C. The direction bit (bit 10, and the dir_down port) is 1 from the tick that leaves C until the tick that leaves 0. The tick that turns the count at C sets the compare flag. The tick that turns it at 0 sets the zero flag (bit 9) and drives zero_pulse high for the following cycle.
- R4: When the shadow-buffer enable (bit 3) is 0, a write to the compare-clear word (select 1) changes the active value at once, and a read returns the new value.
- R5: When bit 3 is 1, a compare-clear write only stages the value. The active value (which is what select 1 reads) takes the staged value on the compare-clear wrap in sawtooth mode, or on the turn at zero in triangle mode.
- R6: With bit 4 = 0, ticks come from cnt_en. With bit 4 = 1, ticks come from rising edges of ext_clk, and cnt_en is ignored. An edge of ext_clk shows in the count within four cycles.
- R7: While the stop bit (bit 0) is 1, ticks are ignored and the count holds its value.
- R8: Writing 1 to the clear bit (bit 1) sets the count to 0 and the direction to up. Bit 1 always reads 0.
- R9: The two flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. irq is high when (compare flag and bit 5) or (zero flag and bit 6).
- R10: A write to the timer data word (select 0) loads the count, and counting resumes from the loaded value.
- R11: Bits 7 and 15:11 of the control/status word read 0. The direction bit cannot be written.
- R12: bus_be[0] enables the write of bits 7:0 and bus_be[1] enables the write of bits 15:8. A byte whose enable is low keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Word select: 0 timer data, 1 compare-clear, 2 control/status, 3 unused (reads 0) |
| bus_wr | input | 1 | Write strobe, taken in the same cycle |
| bus_be | input | 2 | Byte enables for the write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected word (combinational) |
| cnt_en | input | 1 | One-cycle tick from the prescaler |
| ext_clk | input | 1 | Asynchronous external count clock |
| count | output | 16 | Current count |
| dir_down | output | 1 | 1 while counting down |
| cc_pulse | output | 1 | One-cycle compare-clear event |
| zero_pulse | output | 1 | One-cycle zero-turn event |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the local step rules: a sawtooth tick at the compare value goes to zero, the triangle turns at both ends, the count holds while stopped, every event pulse is matched by its flag, flags clear only through a write to the high byte, and the direction stays up in sawtooth mode. The bench shows the behaviour over whole periods. It sweeps small compare values in both modes and checks each count against the closed forms in R2 and R3. It also covers the buffer copy at the correct boundary, source selection with the unused source ignored, byte-lane merging, and interrupt gating. A step rule alone cannot show any of these.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } frt_sel_e;

  // control/status bit positions
  localparam int unsigned CB_STOP  = 0;
  localparam int unsigned CB_CLR   = 1;
  localparam int unsigned CB_UPDN  = 2;
  localparam int unsigned CB_BUFEN = 3;
  localparam int unsigned CB_EXT   = 4;
  localparam int unsigned CB_CCIE  = 5;
  localparam int unsigned CB_ZDIE  = 6;
  localparam int unsigned CB_CCF   = 8;
  localparam int unsigned CB_ZDF   = 9;
  localparam int unsigned CB_DIR   = 10;
endpackage

// File: rtl/frt_tick_src.sv
module frt_tick_src #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic stop,
  input  logic cnt_en,
  input  logic ext_clk,
  output logic tick
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;
  logic         ext_rise;

  genvar s;
  generate
    for (s = 0; s <= MSB; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= ext_clk;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[MSB];

  assign ext_rise = sync_q[MSB] & ~prev_q;
  assign tick     = ~stop & (ext_sel ? ext_rise : cnt_en);
endmodule

// File: rtl/frt_cmp_buf.sv
module frt_cmp_buf #(
  parameter int unsigned W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [W/frt_pkg::BYTE_W-1:0]  be,
  input  logic [W-1:0]                  wdata,
  input  logic                          buf_en,
  input  logic                          xfer,
  output logic [W-1:0]                  act
);
  localparam int unsigned NB = W / frt_pkg::BYTE_W;
  localparam int unsigned BW = frt_pkg::BYTE_W;

  logic [W-1:0] act_q, shd_q, act_m, shd_m, act_n;

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_lane
      assign shd_m[b*BW +: BW] = (wr && be[b]) ? wdata[b*BW +: BW] : shd_q[b*BW +: BW];
      assign act_m[b*BW +: BW] = (wr && be[b]) ? wdata[b*BW +: BW] : act_q[b*BW +: BW];
    end
  endgenerate

  always_comb begin
    if (!buf_en)   act_n = act_m;
    else if (xfer) act_n = shd_q;
    else           act_n = act_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_q <= '1;
      shd_q <= '1;
    end else begin
      act_q <= act_n;
      shd_q <= shd_m;
    end

  assign act = act_q;
endmodule

// File: rtl/frt_core.sv
module frt_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         updown,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] cc_act,
  output logic [W-1:0] cnt,
  output logic         dir_down,
  output logic         cc_evt,
  output logic         zero_evt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_n;
  logic         dir_q, dir_n;

  always_comb begin
    cnt_n    = cnt_q;
    dir_n    = updown ? dir_q : 1'b0;
    cc_evt   = 1'b0;
    zero_evt = 1'b0;
    if (clr) begin
      cnt_n = '0;
      dir_n = 1'b0;
    end else if (ld) begin
      cnt_n = ld_val;
    end else if (tick) begin
      if (!updown) begin
        if (cnt_q == cc_act) begin
          cnt_n  = '0;
          cc_evt = 1'b1;
        end else begin
          cnt_n = cnt_q + ONE;
        end
      end else if (!dir_q) begin
        if (cnt_q >= cc_act) begin
          dir_n  = 1'b1;
          cc_evt = 1'b1;
          cnt_n  = (cnt_q == '0) ? '0 : cnt_q - ONE;
        end else begin
          cnt_n = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          dir_n    = 1'b0;
          zero_evt = 1'b1;
          cnt_n    = (cc_act == '0) ? '0 : ONE;
        end else begin
          cnt_n = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
    end

  assign cnt      = cnt_q;
  assign dir_down = dir_q;
endmodule

// File: rtl/frt_timer.sv
module frt_timer #(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_sel,
  input  logic         bus_wr,
  input  logic [1:0]   bus_be,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         cnt_en,
  input  logic         ext_clk,
  output logic [W-1:0] count,
  output logic         dir_down,
  output logic         cc_pulse,
  output logic         zero_pulse,
  output logic         irq
);
  import frt_pkg::*;

  localparam int unsigned NB = W / BYTE_W;
  localparam int unsigned BW = BYTE_W;

  frt_sel_e sel_e;
  logic     wr_data, wr_cmp, wr_ctrl_lo, wr_ctrl_hi;
  logic     stop_q, updown_q, bufen_q, extsel_q, ccie_q, zdie_q;
  logic     cc_flag_q, zd_flag_q, cc_pulse_q, zero_pulse_q;
  logic     clr, tick, cc_evt, zero_evt, xfer;
  logic [W-1:0] cnt, cc_act, ld_val;
  logic [NB-1:0] be_w;

  assign sel_e      = frt_sel_e'(bus_sel);
  assign be_w       = NB'(bus_be);
  assign wr_data    = bus_wr && (sel_e == SEL_DATA) && (|be_w);
  assign wr_cmp     = bus_wr && (sel_e == SEL_CMP);
  assign wr_ctrl_lo = bus_wr && (sel_e == SEL_CTRL) && bus_be[0];
  assign wr_ctrl_hi = bus_wr && (sel_e == SEL_CTRL) && bus_be[1];
  assign clr        = wr_ctrl_lo && bus_wdata[CB_CLR];

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_ld
      assign ld_val[b*BW +: BW] = be_w[b] ? bus_wdata[b*BW +: BW] : cnt[b*BW +: BW];
    end
  endgenerate

  frt_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_sel(extsel_q), .stop(stop_q),
    .cnt_en(cnt_en), .ext_clk(ext_clk), .tick(tick)
  );

  assign xfer = updown_q ? zero_evt : cc_evt;

  frt_cmp_buf #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr(wr_cmp), .be(be_w), .wdata(bus_wdata),
    .buf_en(bufen_q), .xfer(xfer), .act(cc_act)
  );

  frt_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .updown(updown_q), .clr(clr),
    .ld(wr_data), .ld_val(ld_val), .cc_act(cc_act), .cnt(cnt),
    .dir_down(dir_down), .cc_evt(cc_evt), .zero_evt(zero_evt)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stop_q   <= 1'b0;
      updown_q <= 1'b0;
      bufen_q  <= 1'b0;
      extsel_q <= 1'b0;
      ccie_q   <= 1'b0;
      zdie_q   <= 1'b0;
    end else if (wr_ctrl_lo) begin
      stop_q   <= bus_wdata[CB_STOP];
      updown_q <= bus_wdata[CB_UPDN];
      bufen_q  <= bus_wdata[CB_BUFEN];
      extsel_q <= bus_wdata[CB_EXT];
      ccie_q   <= bus_wdata[CB_CCIE];
      zdie_q   <= bus_wdata[CB_ZDIE];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cc_flag_q    <= 1'b0;
      zd_flag_q    <= 1'b0;
      cc_pulse_q   <= 1'b0;
      zero_pulse_q <= 1'b0;
    end else begin
      cc_flag_q    <= cc_evt   | (cc_flag_q & ~(wr_ctrl_hi & ~bus_wdata[CB_CCF]));
      zd_flag_q    <= zero_evt | (zd_flag_q & ~(wr_ctrl_hi & ~bus_wdata[CB_ZDF]));
      cc_pulse_q   <= cc_evt;
      zero_pulse_q <= zero_evt;
    end

  always_comb begin
    bus_rdata = '0;
    unique case (sel_e)
      SEL_DATA: bus_rdata = cnt;
      SEL_CMP:  bus_rdata = cc_act;
      SEL_CTRL: begin
        bus_rdata[CB_STOP]  = stop_q;
        bus_rdata[CB_UPDN]  = updown_q;
        bus_rdata[CB_BUFEN] = bufen_q;
        bus_rdata[CB_EXT]   = extsel_q;
        bus_rdata[CB_CCIE]  = ccie_q;
        bus_rdata[CB_ZDIE]  = zdie_q;
        bus_rdata[CB_CCF]   = cc_flag_q;
        bus_rdata[CB_ZDF]   = zd_flag_q;
        bus_rdata[CB_DIR]   = dir_down;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign count      = cnt;
  assign cc_pulse   = cc_pulse_q;
  assign zero_pulse = zero_pulse_q;
  assign irq        = (cc_flag_q & ccie_q) | (zd_flag_q & zdie_q);
endmodule

// File: rtl/frt_timer_chk.sv
module frt_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic         ctrl_hi_wr,
  input logic         rd_bit15,
  input logic         sel_ctrl,
  input logic         tick,
  input logic         updown,
  input logic         stop,
  input logic [W-1:0] count,
  input logic [W-1:0] cc_act,
  input logic         dir_down,
  input logic         cc_pulse,
  input logic         zero_pulse,
  input logic         cc_flag,
  input logic         zd_flag
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assert_saw_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!updown && tick && !bus_wr && count == cc_act) |=> (count == '0 && cc_pulse));

  assert_top_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (updown && tick && !bus_wr && !dir_down && count >= cc_act && count != '0)
      |=> (dir_down && count == $past(count) - ONE));

  assert_bottom_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (updown && tick && !bus_wr && dir_down && count == '0) |=> (!dir_down && zero_pulse));

  assert_saw_dir_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !updown |=> !dir_down);

  assert_stop_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !bus_wr) |=> $stable(count));

  assert_cc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_flag && !ctrl_hi_wr) |=> cc_flag);

  assert_zd_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (zd_flag && !ctrl_hi_wr) |=> zd_flag);

  assert_pulse_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_pulse |-> cc_flag) and (zero_pulse |-> zd_flag));

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ctrl |-> !rd_bit15);
endmodule

bind frt_timer frt_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .ctrl_hi_wr(wr_ctrl_hi),
  .rd_bit15(bus_rdata[15]), .sel_ctrl(bus_sel == 2'd2), .tick(tick),
  .updown(updown_q), .stop(stop_q), .count(cnt), .cc_act(cc_act),
  .dir_down(dir_down), .cc_pulse(cc_pulse_q), .zero_pulse(zero_pulse_q),
  .cc_flag(cc_flag_q), .zd_flag(zd_flag_q)
);

// File: tb/frt_timer_tb.sv
module frt_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        cnt_en = 1'b0;
  logic        ext_clk = 1'b0;
  logic [15:0] count;
  logic        dir_down, cc_pulse, zero_pulse, irq;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_en(cnt_en), .ext_clk(ext_clk),
    .count(count), .dir_down(dir_down), .cc_pulse(cc_pulse), .zero_pulse(zero_pulse),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_sel = sel; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] d);
    bus_sel = sel;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_en = 1'b1;
      @(negedge clk); cnt_en = 1'b0;
    end
  endtask

  task automatic ext_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (2) @(negedge clk);
      ext_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int p, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 count", d, 16'h0000);
    rd(2'd1, d); chk("R1 compare", d, 16'hFFFF);
    rd(2'd2, d); chk("R1 control", d, 16'h0000);
    chk("R1 dir", dir_down, 1'b0);

    // R2 sawtooth sweep, R4 direct write, R8 clear
    for (int c = 0; c <= 5; c++) begin
      wr(2'd2, 2'b01, 16'h0002);
      wr(2'd1, 2'b11, 16'(c));
      rd(2'd1, d); chk("R4 direct compare", d, 16'(c));
      for (int n = 0; n <= 2*(c+1)+1; n++) begin
        wr(2'd2, 2'b01, 16'h0002);
        ticks(n);
        rd(2'd0, d); chk("R2 saw count", d, 16'(n % (c+1)));
      end
    end
    wr(2'd1, 2'b11, 16'd3);
    wr(2'd2, 2'b01, 16'h0002);
    ticks(3);
    chk("R2 no early pulse", cc_pulse, 1'b0);
    ticks(1);
    chk("R2 cc_pulse", cc_pulse, 1'b1);
    rd(2'd2, d); chk("R2 cc flag", d[8], 1'b1);
    @(negedge clk); chk("R2 pulse one cycle", cc_pulse, 1'b0);

    // R3 triangle sweep
    for (int c = 1; c <= 4; c++) begin
      wr(2'd1, 2'b11, 16'(c));
      for (int n = 0; n <= 4*c+1; n++) begin
        wr(2'd2, 2'b01, 16'h0006);
        ticks(n);
        p = n % (2*c);
        e = (p <= c) ? p : 2*c - p;
        rd(2'd0, d); chk("R3 tri count", d, 16'(e));
        chk("R3 tri dir", dir_down, ((p > c) || (p == 0 && n > 0)) ? 1'b1 : 1'b0);
      end
    end
    wr(2'd1, 2'b11, 16'd2);
    wr(2'd2, 2'b11, 16'h0006);
    ticks(4);
    chk("R3 no zero yet", zero_pulse, 1'b0);
    ticks(1);
    chk("R3 zero_pulse", zero_pulse, 1'b1);
    rd(2'd2, d); chk("R3 zero flag", d[9], 1'b1);

    // R5 buffered, sawtooth
    wr(2'd2, 2'b01, 16'h0002);
    wr(2'd1, 2'b11, 16'd3);
    wr(2'd2, 2'b01, 16'h000A);
    wr(2'd1, 2'b11, 16'd5);
    rd(2'd1, d); chk("R5 staged only", d, 16'd3);
    ticks(3);
    rd(2'd1, d); chk("R5 held before wrap", d, 16'd3);
    ticks(1);
    rd(2'd0, d); chk("R5 wrap at old value", d, 16'd0);
    rd(2'd1, d); chk("R5 copied at wrap", d, 16'd5);
    ticks(6);
    rd(2'd0, d); chk("R5 new period", d, 16'd0);

    // R5 buffered, triangle
    wr(2'd2, 2'b01, 16'h0002);
    wr(2'd1, 2'b11, 16'd3);
    wr(2'd2, 2'b01, 16'h000E);
    wr(2'd1, 2'b11, 16'd2);
    ticks(4);
    rd(2'd0, d); chk("R5 tri old top", d, 16'd2);
    rd(2'd1, d); chk("R5 tri not at top", d, 16'd3);
    ticks(2);
    rd(2'd1, d); chk("R5 tri not before zero turn", d, 16'd3);
    ticks(1);
    rd(2'd1, d); chk("R5 tri copied at zero", d, 16'd2);
    ticks(2);
    rd(2'd0, d); chk("R5 tri new top", d, 16'd1);

    // R6 source selection
    wr(2'd2, 2'b01, 16'h0002);
    wr(2'd1, 2'b11, 16'hFFFF);
    wr(2'd2, 2'b01, 16'h0012);
    ticks(3);
    rd(2'd0, d); chk("R6 cnt_en ignored", d, 16'd0);
    ext_edges(5);
    rd(2'd0, d); chk("R6 ext edges", d, 16'd5);
    wr(2'd2, 2'b01, 16'h0000);
    ext_edges(2);
    rd(2'd0, d); chk("R6 ext ignored", d, 16'd5);
    ticks(1);
    rd(2'd0, d); chk("R6 internal tick", d, 16'd6);

    // R7 stop
    wr(2'd2, 2'b01, 16'h0001);
    ticks(3);
    rd(2'd0, d); chk("R7 frozen", d, 16'd6);
    wr(2'd2, 2'b01, 16'h0000);
    ticks(1);
    rd(2'd0, d); chk("R7 resumes", d, 16'd7);

    // R10 data load, R12 byte lanes
    wr(2'd0, 2'b11, 16'h1234);
    rd(2'd0, d); chk("R10 load", d, 16'h1234);
    ticks(1);
    rd(2'd0, d); chk("R10 count on", d, 16'h1235);
    wr(2'd0, 2'b10, 16'hAB00);
    rd(2'd0, d); chk("R12 high lane only", d, 16'hAB35);
    wr(2'd1, 2'b01, 16'h0077);
    rd(2'd1, d); chk("R12 low lane only", d, 16'hFF77);

    // R8 clear
    wr(2'd2, 2'b01, 16'h0002);
    rd(2'd0, d); chk("R8 cleared", d, 16'h0000);
    rd(2'd2, d); chk("R8 clear reads 0", d[1], 1'b0);

    // R9 flags and interrupt
    wr(2'd2, 2'b10, 16'h0000);
    rd(2'd2, d); chk("R9 flags cleared", d[9:8], 2'b00);
    chk("R9 irq low", irq, 1'b0);
    wr(2'd1, 2'b11, 16'd2);
    wr(2'd2, 2'b01, 16'h0022);
    ticks(3);
    chk("R9 irq from compare", irq, 1'b1);
    wr(2'd2, 2'b10, 16'h0300);
    rd(2'd2, d); chk("R9 write 1 keeps", d[8], 1'b1);
    wr(2'd2, 2'b10, 16'h0000);
    rd(2'd2, d); chk("R9 write 0 clears", d[8], 1'b0);
    chk("R9 irq drops", irq, 1'b0);
    wr(2'd2, 2'b01, 16'h0046);
    ticks(3);
    rd(2'd2, d); chk("R9 compare flag set", d[8], 1'b1);
    chk("R9 masked compare", irq, 1'b0);
    ticks(2);
    chk("R9 irq from zero", irq, 1'b1);

    // R11 reserved and read-only bits
    wr(2'd2, 2'b10, 16'hFFFF);
    rd(2'd2, d); chk("R11 reserved high", d[15:10], 6'b000000);
    chk("R11 bit7", d[7], 1'b0);
    rd(2'd3, d); chk("R11 unused select", d, 16'h0000);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule